// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into a framed asynchronous bit stream on one output line. A CPU-side producer offers a character over a valid/ready stream port. The block keeps it in a one-entry holding register and hands it to a shift register on the next falling edge of the transmit clock. Each character goes out as a low start bit, then the active data bits with the least significant bit first, then an optional parity bit, then high stop bits. Bits change only on falling edges of the transmit clock, which is sampled in the system clock domain, and each bit lasts 1, 16 or 64 transmit-clock periods.

An 8-bit mode input sets the frame format. The block samples it when a character moves from the holding register into the shifter, so a new format applies from the next character on. Back-pressure is simple. A character is accepted on any system clock edge where `tx_valid_i` and `tx_ready_o` are both high. While `tx_ready_o` is low, the producer holds `tx_valid_i` and `tx_data_i` steady. The ready output rises again on the transmit-clock edge that starts sending the held character, so the next character can wait while the current one shifts out.

A break input forces the line low at once, whatever the shifter is doing. Framing keeps running underneath it. Clock-factor code 00 is not a supported format and sends as 1x.

Top module: `serial_tx`

## Requirements
- R1: After reset, `txd_o` is high and `tx_ready_o` is high.
- R2: Mode bits [3:2] set the character length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 data bits. Data bits are sent least significant bit first, and data bits above the set length are never sent.
- R3: Mode bit 4 = 1 inserts a parity bit after the data bits. Mode bit 5 = 1 selects even parity and 0 selects odd. Parity is computed over the active data bits only.
- R4: Mode bits [7:6] set the stop time, always at high level. 01 = one bit time. 10 = 1.5 bit times, which is 24 transmit-clock periods at 16x, 96 at 64x, and 2 bit times at 1x. 11 = two bit times. 00 behaves like 01.
- R5: Mode bits [1:0] set the bit time in transmit-clock periods: 01 = 1, 10 = 16, 11 = 64.
- R6: The line changes only on the system clock edge that detects a falling edge of `txc_i`. The start bit begins on the first such edge after a character is held.
- R7: A character is accepted when `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` stays low while the holding register is occupied, and rises on the transmit-clock edge that moves the character into the shifter.
- R8: A character that is already held when the stop time ends starts its start bit on that same transmit-clock edge, with no idle time between frames.
- R9: While `brk_i` is high, `txd_o` is low. Framing continues underneath, so the line shows the frame in progress once break is released.
- R10: The mode is captured when a frame starts. A change of `mode_i` during a frame affects only later frames.
- R11: With no character to send and no break, `txd_o` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txc_i | input | 1 | Transmit clock, synchronous to `clk`, slower than half its rate |
| mode_i | input | 8 | Frame format byte |
| tx_valid_i | input | 1 | A character is offered |
| tx_data_i | input | DW (8) | Offered character |
| tx_ready_o | output | 1 | Holding register empty; the character is taken when valid is also high |
| brk_i | input | 1 | Force the line low |
| txd_o | output | 1 | Serial line |

## Verification
Most internal faults show on `txd_o` within one bit time. A wrong bit counter or captured length puts a stop level where a data bit belongs, or the reverse. A wrong parity sense flips one bit. A sub-counter fault stretches or shrinks every bit and shows within one bit period. A stuck holding flag shows on `tx_ready_o` in the system clock cycle after an accept or a transmit-clock edge. A mishandled hand-over between frames shows as an idle high level on the one edge where the next start bit was due. The bench compares the line level after every transmit-clock falling edge against a model built from the mode fields, so such faults are caught on the edge where they first appear.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  localparam int unsigned STX_DW = 8;
  localparam int unsigned STX_CW = 7;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_BITS  = 2'd1,
    TX_XSTOP = 2'd2
  } tx_state_e;
endpackage

// File: rtl/stx_edge.sv
module stx_edge #(
  parameter logic INIT_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txc_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= INIT_LVL;
    else        prev_q <= txc_i;
  end

  assign fall_o = prev_q & ~txc_i;
endmodule

// File: rtl/stx_hold.sv
module stx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic          ready_o,
  input  logic          take_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);
  logic          full_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (valid_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign ready_o = ~full_q;
  assign full_o  = full_q;
  assign data_o  = data_q;
endmodule

// File: rtl/stx_frame.sv
module stx_frame #(
  parameter int unsigned DW = 8,
  parameter int unsigned FW = DW + 3,
  parameter int unsigned NW = $clog2(FW + 1),
  parameter int unsigned CW = 7
) (
  input  logic [7:0]    mode_i,
  input  logic [DW-1:0] data_i,
  output logic [FW-1:0] bits_o,
  output logic [NW-1:0] nbits_o,
  output logic [CW-1:0] div_o,
  output logic [CW-1:0] ext_o
);
  logic [NW-1:0] nchar;
  logic          par;

  always_comb begin
    nchar  = NW'(5) + NW'(mode_i[3:2]);
    par    = 1'b0;
    bits_o = '1;
    bits_o[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (NW'(i) < nchar) begin
        bits_o[i+1] = data_i[i];
        par         = par ^ data_i[i];
      end
    end
    par = par ^ ~mode_i[5];
    if (mode_i[4]) begin
      for (int j = 0; j < FW; j++) begin
        if (NW'(j) == nchar + NW'(1)) bits_o[j] = par;
      end
    end
    nbits_o = nchar + NW'(2) + NW'(mode_i[4]);
  end

  always_comb begin
    case (mode_i[1:0])
      2'b10:   div_o = CW'(16);
      2'b11:   div_o = CW'(64);
      default: div_o = CW'(1);
    endcase
    case (mode_i[7:6])
      2'b10:   ext_o = (div_o == CW'(1)) ? CW'(1) : (div_o >> 1);
      2'b11:   ext_o = div_o;
      default: ext_o = '0;
    endcase
  end
endmodule

// File: rtl/stx_shift.sv
module stx_shift
  import serial_tx_pkg::*;
#(
  parameter int unsigned FW = 11,
  parameter int unsigned NW = 4,
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          have_i,
  input  logic [FW-1:0] bits_i,
  input  logic [NW-1:0] nbits_i,
  input  logic [CW-1:0] div_i,
  input  logic [CW-1:0] ext_i,
  output logic          take_o,
  output logic          line_o
);
  tx_state_e     state_q;
  logic [FW-1:0] sh_q;
  logic [NW-1:0] left_q;
  logic [CW-1:0] sub_q, div_q, ext_q;
  logic          bit_end, ext_end, finish;

  assign bit_end = (sub_q == div_q - CW'(1));
  assign ext_end = (sub_q == ext_q - CW'(1));
  assign finish  = (state_q == TX_BITS && bit_end && left_q == NW'(1) && ext_q == '0)
                || (state_q == TX_XSTOP && ext_end);
  assign take_o  = tick_i && have_i && (state_q == TX_IDLE || finish);
  assign line_o  = (state_q == TX_BITS) ? sh_q[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      sh_q    <= '1;
      left_q  <= '0;
      sub_q   <= '0;
      div_q   <= CW'(1);
      ext_q   <= '0;
    end else if (tick_i) begin
      if (take_o) begin
        state_q <= TX_BITS;
        sh_q    <= bits_i;
        left_q  <= nbits_i;
        sub_q   <= '0;
        div_q   <= div_i;
        ext_q   <= ext_i;
      end else begin
        case (state_q)
          TX_BITS: begin
            if (bit_end) begin
              sub_q <= '0;
              if (left_q == NW'(1)) begin
                state_q <= (ext_q != '0) ? TX_XSTOP : TX_IDLE;
              end else begin
                left_q <= left_q - NW'(1);
                sh_q   <= {1'b1, sh_q[FW-1:1]};
              end
            end else begin
              sub_q <= sub_q + CW'(1);
            end
          end
          TX_XSTOP: begin
            if (ext_end) state_q <= TX_IDLE;
            else         sub_q   <= sub_q + CW'(1);
          end
          default: state_q <= TX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import serial_tx_pkg::*;
#(
  parameter int unsigned DW = STX_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txc_i,
  input  logic [7:0]    mode_i,
  input  logic          tx_valid_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          tx_ready_o,
  input  logic          brk_i,
  output logic          txd_o
);
  localparam int unsigned FW = DW + 3;
  localparam int unsigned NW = $clog2(FW + 1);
  localparam int unsigned CW = STX_CW;

  logic          fall_w, take_w, full_w, line_w;
  logic [DW-1:0] held_w;
  logic [FW-1:0] bits_w;
  logic [NW-1:0] nbits_w;
  logic [CW-1:0] div_w, ext_w;

  stx_edge #(.INIT_LVL(1'b0)) u_edge (
    .clk(clk), .rst_n(rst_n), .txc_i(txc_i), .fall_o(fall_w)
  );

  stx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .valid_i(tx_valid_i), .data_i(tx_data_i),
    .ready_o(tx_ready_o), .take_i(take_w), .full_o(full_w), .data_o(held_w)
  );

  stx_frame #(.DW(DW), .FW(FW), .NW(NW), .CW(CW)) u_frame (
    .mode_i(mode_i), .data_i(held_w), .bits_o(bits_w), .nbits_o(nbits_w),
    .div_o(div_w), .ext_o(ext_w)
  );

  stx_shift #(.FW(FW), .NW(NW), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick_i(fall_w), .have_i(full_w),
    .bits_i(bits_w), .nbits_i(nbits_w), .div_i(div_w), .ext_i(ext_w),
    .take_o(take_w), .line_o(line_w)
  );

  assign txd_o = brk_i ? 1'b0 : line_w;
endmodule

// File: rtl/stx_chk.sv
module stx_chk (
  input logic clk,
  input logic rst_n,
  input logic fall,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic brk_i,
  input logic txd_o
);
  // R7
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready_o && !fall) |=> !tx_ready_o);

  // R9
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |-> !txd_o);

  // R6
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !brk_i) |=> (brk_i || $stable(txd_o)));

  // R6
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_ready_o) && !brk_i) |-> !txd_o);
endmodule

bind serial_tx stx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fall(fall_w), .tx_valid_i(tx_valid_i),
  .tx_ready_o(tx_ready_o), .brk_i(brk_i), .txd_o(txd_o)
);

// File: tb/tb_serial_tx.sv
module tb_serial_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txc = 1'b0;
  logic [7:0] mode = 8'h4D;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready;
  logic       brk = 1'b0;
  logic       txd;
  int         total = 0;
  int         bad = 0;

  always #4 clk = ~clk;

  serial_tx dut (
    .clk(clk), .rst_n(rst_n), .txc_i(txc), .mode_i(mode),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .brk_i(brk), .txd_o(txd)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int fac(input logic [7:0] m);
    return (m[1:0] == 2'b10) ? 16 : (m[1:0] == 2'b11) ? 64 : 1;
  endfunction

  function automatic int frame_len(input logic [7:0] m);
    int n = 5 + int'(m[3:2]);
    int d = fac(m);
    int x = (m[7:6] == 2'b10) ? ((d == 1) ? 1 : d / 2) : (m[7:6] == 2'b11) ? d : 0;
    return d * (2 + n + int'(m[4])) + x;
  endfunction

  function automatic logic exp_level(input logic [7:0] m, input logic [7:0] d, input int k);
    int n = 5 + int'(m[3:2]);
    int b = k / fac(m);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += int'(d[i]);
    if (b == 0) return 1'b0;
    if (b <= n) return d[b-1];
    if (m[4] && b == n + 1) return m[5] ? logic'(ones % 2) : logic'(1 - ones % 2);
    return 1'b1;
  endfunction

  task automatic fall_txc();
    @(negedge clk) txc = 1'b1;
    @(negedge clk) txc = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R7", "ready after accept", tx_ready, 0);
  endtask

  task automatic run_frame(input logic [7:0] m, input logic [7:0] d, input int k0,
                           input bit nxt, input logic [7:0] m_after, input string tag);
    int tot = frame_len(m);
    int errs = 0;
    logic e;
    for (int k = k0; k <= tot; k++) begin
      fall_txc();
      if (k == 0) begin
        chk(tx_ready == 1'b1, "R7", "ready at frame start", tx_ready, 1);
        mode = m_after;
        if (tx_valid) begin
          @(negedge clk);
          tx_valid = 1'b0;
        end
      end
      e = (k == tot) ? ~nxt : exp_level(m, d, k);
      if (txd !== e) begin
        if (errs == 0)
          $display("FAIL %s frame m=%0h d=%0h fall=%0d act=%b exp=%b", tag, m, d, k, txd, e);
        errs++;
      end
    end
    total++;
    if (errs != 0) bad++;
  endtask

  task automatic t_reset();
    chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
    chk(tx_ready == 1'b1, "R1", "ready after reset", tx_ready, 1);
  endtask

  task automatic t_simple(input logic [7:0] m, input logic [7:0] d, input string tag);
    mode = m;
    push(d);
    run_frame(m, d, 0, 1'b0, m, tag);
  endtask

  task automatic t_idle();
    int errs = 0;
    for (int k = 0; k < 5; k++) begin
      fall_txc();
      if (txd !== 1'b1) errs++;
    end
    chk(errs == 0, "R11", "idle marking", errs, 0);
  endtask

  task automatic t_break_idle();
    int errs = 0;
    @(negedge clk) brk = 1'b1;
    #1 chk(txd == 1'b0, "R9", "break immediate", txd, 0);
    for (int k = 0; k < 3; k++) begin
      fall_txc();
      if (txd !== 1'b0) errs++;
    end
    chk(errs == 0, "R9", "break held", errs, 0);
    @(negedge clk) brk = 1'b0;
    #1 chk(txd == 1'b1, "R11", "marking after break", txd, 1);
  endtask

  task automatic t_break_mid();
    int errs = 0;
    mode = 8'h4D;
    push(8'h96);
    @(negedge clk) brk = 1'b1;
    for (int k = 0; k < 4; k++) begin
      fall_txc();
      if (txd !== 1'b0) errs++;
    end
    chk(errs == 0, "R9", "break over frame", errs, 0);
    @(negedge clk) brk = 1'b0;
    run_frame(8'h4D, 8'h96, 4, 1'b0, 8'h4D, "R9");
  endtask

  task automatic t_back_to_back();
    int errs = 0;
    mode = 8'h4D;
    push(8'h3C);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = 8'hE7;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (tx_ready !== 1'b0 || txd !== 1'b1) errs++;
    end
    chk(errs == 0, "R7", "back-pressure hold", errs, 0);
    run_frame(8'h4D, 8'h3C, 0, 1'b1, 8'hD1, "R10");
    run_frame(8'hD1, 8'hE7, 1, 1'b0, 8'hD1, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_simple(8'h4D, 8'hA5, "R2");
    t_simple(8'h7A, 8'hDB, "R3");
    t_simple(8'hD1, 8'hFF, "R3");
    t_simple(8'h86, 8'h2C, "R4");
    t_simple(8'h8D, 8'h71, "R4");
    t_simple(8'hBF, 8'h5A, "R5");
    t_simple(8'h0D, 8'hC3, "R4");
    t_simple(8'h56, 8'h0B, "R6");
    t_idle();
    t_break_idle();
    t_break_mid();
    t_back_to_back();
    t_idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule